// File: doc/BRIEF.md
# Translate-and-Scan String Engine

The engine runs one string scan per start command. It pulls source bytes from a byte-serial valid/ready port and maps each byte through a 256-entry translation table in local RAM. The table is loaded through a write port. Leading bytes that map to zero are dropped. The mapped bytes that follow go out on a valid/ready destination port. Copying ends at the first byte that maps to zero. The rest of the destination field is then padded with the byte held in table entry 0.

At the end, the engine presents several results on output ports: the number of bytes it wrote in translated form, the number of source bytes it scanned, a three-way condition code and an overflow flag. The operand length is given as length minus one, so the source field and the destination field each hold `len_i + 1` bytes. A source byte of value 0x00 is illegal. It aborts the scan at once and raises overflow.

Top module: `xlat_scan_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, dst_valid_o and src_ready_o are low, both counts are zero, cc_o is 2'b00 and ovf_o is 0.
- R2: Leading source bytes whose table entry is zero are consumed without producing any destination byte.
- R3: After the first nonzero translation, each translated byte is sent on the destination port in source order. The first later byte whose translation is zero ends copying, and that byte is not sent.
- R4: xlat_cnt_o reports the number of translated bytes sent before padding.
- R5: scan_cnt_o reports skipped bytes plus translated bytes. A terminating byte and an illegal 0x00 byte are not counted.
- R6: Unless overflow occurred, the destination receives exactly len_i+1 bytes in total: the translated bytes first, then copies of table entry 0.
- R7: A source byte of 0x00 stops the scan before translation. It sets ovf_o, and no further destination bytes, padding included, are produced for that operation.
- R8: cc_o is 2'b00 when a terminating zero translation was found within the length, 2'b01 when the length ran out (or overflow hit) after at least one translated byte, and 2'b10 when no byte was translated.
- R9: len_i holds the length minus one (len_i=0 means one byte). No more than len_i+1 source bytes are accepted, and no source bytes are accepted after the scan ends.
- R10: done_o is high for exactly one cycle at the end of each operation. src_ready_o is low whenever the engine is idle.
- R11: While dst_valid_o is high and dst_ready_i is low, dst_valid_o stays high and dst_data_o stays constant, so back-pressure loses no byte.
- R12: A table write takes effect for later operations; a new value in entry 0 changes the padding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Table write address |
| tbl_data_i | input | 8 | Table write data |
| start_i | input | 1 | Start an operation (sampled while idle) |
| len_i | input | LEN_W | Operand length minus one |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Engine accepts a source byte |
| dst_valid_o | output | 1 | Destination byte valid |
| dst_data_o | output | 8 | Destination byte |
| dst_ready_i | input | 1 | Destination accepts a byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| xlat_cnt_o | output | LEN_W+1 | Translated byte count |
| scan_cnt_o | output | LEN_W+1 | Skipped plus translated count |
| cc_o | output | 2 | Condition code: 00 zero, 01 positive, 10 negative |
| ovf_o | output | 1 | Illegal 0x00 source byte seen |

## Verification
Some properties are checked every cycle by the assertions: destination back-pressure stability, the single-cycle done pulse, a quiet source port while idle, no destination traffic after overflow, a scan count that never falls below the translated count, and a legal condition code. The bench scenarios are needed to show the actual byte stream and counts. They cover the skip, copy and pad order, the length limit on source consumption, the choice among the three condition codes, the abort on a 0x00 byte, and the effect of rewriting table entry 0. A reference model in the bench predicts each of these from the table contents.

// File: rtl/xse_pkg.sv
package xse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SKIP, ST_COPY, ST_FILL, ST_DONE
  } xse_state_e;

  localparam logic [1:0] CC_ZERO = 2'b00;
  localparam logic [1:0] CC_POS  = 2'b01;
  localparam logic [1:0] CC_NEG  = 2'b10;
endpackage

// File: rtl/xse_xlat_ram.sv
module xse_xlat_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ent0_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

  // entry 0 shadow: pad byte without a second read port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ent0_o <= '0;
    else if (we_i && (waddr_i == '0))   ent0_o <= wdata_i;
  end
endmodule

// File: rtl/xse_scan_fsm.sv
module xse_scan_fsm
  import xse_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             src_valid_i,
  input  logic [DW-1:0]    src_data_i,
  output logic             src_ready_o,
  output logic             lkp_re_o,
  output logic [DW-1:0]    lkp_addr_o,
  input  logic [DW-1:0]    lkp_data_i,
  input  logic [DW-1:0]    ent0_i,
  output logic             dst_valid_o,
  output logic [DW-1:0]    dst_data_o,
  input  logic             dst_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W:0]   xlat_cnt_o,
  output logic [LEN_W:0]   scan_cnt_o,
  output logic [1:0]       cc_o,
  output logic             ovf_o
);
  localparam int CNT_W = LEN_W + 1;

  xse_state_e       state_q;
  logic             pend_q;
  logic [DW-1:0]    src_q;
  logic [CNT_W-1:0] n_q, fetched_q, skip_q, copy_q, fill_q;
  logic [1:0]       cc_q;
  logic             ovf_q;

  logic scanning, accept, src_zero, tz, last;

  assign scanning    = (state_q == ST_SKIP) || (state_q == ST_COPY);
  assign src_ready_o = scanning && !pend_q && (fetched_q != n_q);
  assign accept      = src_ready_o && src_valid_i;
  assign lkp_re_o    = accept;
  assign lkp_addr_o  = src_data_i;

  assign src_zero = (src_q == '0);
  assign tz       = (lkp_data_i == '0);
  assign last     = (fetched_q == n_q);

  assign dst_valid_o = (scanning && pend_q && !src_zero && !tz) || (state_q == ST_FILL);
  assign dst_data_o  = (state_q == ST_FILL) ? ent0_i : lkp_data_i;

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign xlat_cnt_o = copy_q;
  assign scan_cnt_o = skip_q + copy_q;
  assign cc_o       = cc_q;
  assign ovf_o      = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      src_q     <= '0;
      n_q       <= '0;
      fetched_q <= '0;
      skip_q    <= '0;
      copy_q    <= '0;
      fill_q    <= '0;
      cc_q      <= CC_ZERO;
      ovf_q     <= 1'b0;
    end else begin
      if (accept) begin
        pend_q    <= 1'b1;
        src_q     <= src_data_i;
        fetched_q <= fetched_q + CNT_W'(1);
      end
      case (state_q)
        ST_IDLE: if (start_i) begin
          n_q       <= {1'b0, len_i} + CNT_W'(1);
          fetched_q <= '0;
          skip_q    <= '0;
          copy_q    <= '0;
          pend_q    <= 1'b0;
          cc_q      <= CC_ZERO;
          ovf_q     <= 1'b0;
          state_q   <= ST_SKIP;
        end
        ST_SKIP, ST_COPY: if (pend_q) begin
          if (src_zero) begin
            pend_q  <= 1'b0;
            ovf_q   <= 1'b1;
            cc_q    <= (copy_q != '0) ? CC_POS : CC_NEG;
            state_q <= ST_DONE;
          end else if (tz) begin
            pend_q <= 1'b0;
            if (state_q == ST_COPY) begin
              cc_q    <= CC_ZERO;
              fill_q  <= n_q - copy_q;
              state_q <= ST_FILL;
            end else begin
              skip_q <= skip_q + CNT_W'(1);
              if (last) begin
                cc_q    <= CC_NEG;
                fill_q  <= n_q;
                state_q <= ST_FILL;
              end
            end
          end else if (dst_ready_i) begin
            pend_q  <= 1'b0;
            copy_q  <= copy_q + CNT_W'(1);
            state_q <= ST_COPY;
            if (last) begin
              cc_q <= CC_POS;
              if (n_q - copy_q - CNT_W'(1) != '0) begin
                fill_q  <= n_q - copy_q - CNT_W'(1);
                state_q <= ST_FILL;
              end else begin
                state_q <= ST_DONE;
              end
            end
          end
        end
        ST_FILL: if (dst_ready_i) begin
          fill_q <= fill_q - CNT_W'(1);
          if (fill_q == CNT_W'(1)) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_scan_engine.sv
module xlat_scan_engine #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [7:0]       tbl_addr_i,
  input  logic [7:0]       tbl_data_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  output logic             src_ready_o,
  output logic             dst_valid_o,
  output logic [7:0]       dst_data_o,
  input  logic             dst_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W:0]   xlat_cnt_o,
  output logic [LEN_W:0]   scan_cnt_o,
  output logic [1:0]       cc_o,
  output logic             ovf_o
);
  logic       lkp_re;
  logic [7:0] lkp_addr, lkp_data, ent0;

  xse_xlat_ram #(.AW(8), .DW(8)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .re_i    (lkp_re),
    .raddr_i (lkp_addr),
    .rdata_o (lkp_data),
    .ent0_o  (ent0)
  );

  xse_scan_fsm #(.LEN_W(LEN_W), .DW(8)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (len_i),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_ready_o (src_ready_o),
    .lkp_re_o    (lkp_re),
    .lkp_addr_o  (lkp_addr),
    .lkp_data_i  (lkp_data),
    .ent0_i      (ent0),
    .dst_valid_o (dst_valid_o),
    .dst_data_o  (dst_data_o),
    .dst_ready_i (dst_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .xlat_cnt_o  (xlat_cnt_o),
    .scan_cnt_o  (scan_cnt_o),
    .cc_o        (cc_o),
    .ovf_o       (ovf_o)
  );
endmodule

// File: rtl/xse_checker.sv
module xse_checker #(
  parameter int LEN_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           src_ready_o,
  input logic           dst_valid_o,
  input logic [7:0]     dst_data_o,
  input logic           dst_ready_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [LEN_W:0] xlat_cnt_o,
  input logic [LEN_W:0] scan_cnt_o,
  input logic [1:0]     cc_o,
  input logic           ovf_o
);
  p_dst_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o && !dst_ready_i |=> dst_valid_o && $stable(dst_data_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_src_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !src_ready_o);

  p_scan_ge_xlat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_cnt_o >= xlat_cnt_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !dst_valid_o);

  p_cc_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_o != 2'b11);
endmodule

bind xlat_scan_engine xse_checker #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_ready_o (src_ready_o),
  .dst_valid_o (dst_valid_o),
  .dst_data_o  (dst_data_o),
  .dst_ready_i (dst_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .xlat_cnt_o  (xlat_cnt_o),
  .scan_cnt_o  (scan_cnt_o),
  .cc_o        (cc_o),
  .ovf_o       (ovf_o)
);

// File: tb/xlat_scan_engine_tb_top.sv
`timescale 1ns/1ps
module xlat_scan_engine_tb_top;
  localparam int LEN_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tbl_we_i = 1'b0;
  logic [7:0] tbl_addr_i = '0, tbl_data_i = '0;
  logic start_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic src_valid_i = 1'b0;
  logic [7:0] src_data_i = '0;
  logic src_ready_o, dst_valid_o, dst_ready_i, busy_o, done_o, ovf_o;
  logic [7:0] dst_data_o;
  logic [LEN_W:0] xlat_cnt_o, scan_cnt_o;
  logic [1:0] cc_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  xlat_scan_engine #(.LEN_W(LEN_W)) dut_i (.*);

  int checks = 0, fails = 0, cyc = 0, dst_seen = 0;
  logic [7:0] tbl_m [256];
  logic [7:0] src_m [64];
  logic [7:0] exp_q [$];
  string cur_req = "R3";

  initial dst_ready_i = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // monitor: pop scoreboard on every destination transfer
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && dst_valid_o && dst_ready_i) begin
      dst_seen++;
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected byte", int'(dst_data_o), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(dst_data_o == e, cur_req, int'(dst_data_o), int'(e));
      end
    end
  end

  task automatic load_table(input logic [7:0] pad);
    for (int a = 0; a < 256; a++) begin
      if (a >= 65 && a <= 90) tbl_m[a] = 8'(a + 32);  // upper -> lower
      else if (a >= 97 && a <= 122) tbl_m[a] = 8'(a);
      else tbl_m[a] = 8'h00;
    end
    tbl_m[0] = pad;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk_i);
      tbl_we_i = 1'b1; tbl_addr_i = 8'(a); tbl_data_i = tbl_m[a];
    end
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic write_entry(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_addr_i = a; tbl_data_i = d;
    tbl_m[a] = d;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  // driver: builds expectation from the model, then streams the source
  task automatic run_op(input string s, input int zidx, input bit stall, input string req);
    int n, skip, copy, cons, ecc, src_cnt, t0;
    bit ovf, found, in_copy;
    n = s.len();
    for (int i = 0; i < n; i++) src_m[i] = (i == zidx) ? 8'h00 : s[i];
    skip = 0; copy = 0; cons = 0; ovf = 0; found = 0; in_copy = 0; ecc = 0;
    for (int i = 0; i < n; i++) begin
      cons++;
      if (src_m[i] == 8'h00) begin ovf = 1; break; end
      if (tbl_m[src_m[i]] == 8'h00) begin
        if (in_copy) begin found = 1; break; end
        skip++;
      end else begin
        in_copy = 1; copy++; exp_q.push_back(tbl_m[src_m[i]]);
      end
    end
    if (found) ecc = 0; else ecc = (copy != 0) ? 1 : 2;
    if (!ovf) for (int i = 0; i < n - copy; i++) exp_q.push_back(tbl_m[0]);
    cur_req = req;
    dst_seen = 0;
    @(negedge clk_i);
    start_i = 1'b1; len_i = LEN_W'(n - 1);
    @(negedge clk_i);
    start_i = 1'b0;
    src_cnt = 0; t0 = cyc;
    forever begin
      @(negedge clk_i);
      src_valid_i = (src_cnt < n);
      src_data_i  = (src_cnt < n) ? src_m[src_cnt] : 8'h00;
      dst_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (src_valid_i && src_ready_o) src_cnt++;
      if (done_o || (cyc - t0 > 5000)) break;
    end
    src_valid_i = 1'b0; dst_ready_i = 1'b1;
    #2;
    check(int'(xlat_cnt_o) == copy, "R4 xlat count", int'(xlat_cnt_o), copy);
    check(int'(scan_cnt_o) == skip + copy, "R5 scan count", int'(scan_cnt_o), skip + copy);
    check(int'(cc_o) == ecc, "R8 cc", int'(cc_o), ecc);
    check(ovf_o == ovf, "R7 overflow flag", int'(ovf_o), int'(ovf));
    check(src_cnt == cons, "R9 source bytes consumed", src_cnt, cons);
    check(dst_seen == (ovf ? copy : n), "R6 destination total", dst_seen, ovf ? copy : n);
    check(exp_q.size() == 0, "R6 missing bytes", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk_i);
    check(!done_o, "R10 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    #20;
    check(!busy_o && !done_o && !dst_valid_o && !src_ready_o, "R1 idle after reset",
          int'({busy_o, done_o, dst_valid_o, src_ready_o}), 0);
    check(xlat_cnt_o == 0 && scan_cnt_o == 0 && cc_o == 0 && !ovf_o, "R1 results after reset",
          int'(xlat_cnt_o) + int'(scan_cnt_o) + int'(cc_o) + int'(ovf_o), 0);
    rst_ni = 1'b1;
    load_table(8'h2E);
    run_op("  HI THERE", -1, 1'b0, "R2 R3 skip then copy then pad");
    run_op("  ABC", -1, 1'b0, "R3 length runs out while copying");
    run_op("  ..", -1, 1'b0, "R2 all bytes translate to zero");
    run_op(" AB-CD", 3, 1'b0, "R7 zero source byte mid copy");
    run_op("-XY", 0, 1'b0, "R7 zero source byte first");
    run_op("Q", -1, 1'b0, "R9 single byte length");
    run_op("   Word break here", -1, 1'b1, "R11 destination stall");
    write_entry(8'h00, 8'h2A);
    run_op(" Zz  ", -1, 1'b0, "R12 new pad byte");
    write_entry(8'h5A, 8'h00);
    run_op(" xZy ", -1, 1'b0, "R12 rewritten entry terminates");
    check(!busy_o && !src_ready_o, "R10 idle source quiet", int'({busy_o, src_ready_o}), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule